// File: doc/BRIEF.md
# Interval Down-Counter Interrupt Timer

This block is a presettable binary down counter that raises an interrupt when it runs out. Each decrement is driven by one of four single-cycle tick enables, and a two-bit register field selects which one: a fast 4096 Hz tick, a 64 Hz tick, a once-per-second tick or a once-per-minute tick. The tick generators sit outside the block. When the count steps from one to zero the block sets a sticky event flag that only a software clear strobe resets, and it may also pull the interrupt line low.

There are two interrupt disciplines. In one-shot mode the counter stops at zero, and the interrupt line stays pulled low until software clears the flag. In repeating mode the counter reloads the preset each time it reaches zero, so events recur with a fixed period. In that mode the line is pulled low for a short window of 16 fast ticks (about 3.9 ms) while the flag stays set. When the enable bit is low the counter is loaded with the preset and held there. A preset of zero never produces an event. The interrupt output is a pull-down enable for an open-drain pin: 1 means drive low and 0 means release.

Top module: `interval_timer`

## Requirements
- R1: `src_sel` picks the decrement tick: 0 = `tick_4k`, 1 = `tick_64`, 2 = `tick_sec`, 3 = `tick_min`. The unselected ticks leave `count` unchanged.
- R2: While `run_en` is 0, `count` takes `preset` one cycle later and holds it whatever the ticks do. After `run_en` rises, counting starts from the preset, and there is no pause state.
- R3: When a selected tick arrives with `count` equal to 1 and `run_en` at 1, `flag` reads 1 on the following cycle.
- R4: With `repeat_mode` at 1, `count` reloads `preset` on that same event instead of reaching 0, so events recur every `preset` selected ticks.
- R5: With `repeat_mode` at 0, `count` stays at 0 after the event, and further ticks produce no new event.
- R6: In one-shot mode, `irq_pull` is 1 while `flag` is 1 and `irq_en` is 1. A `flag_clr` strobe clears both on the next cycle.
- R7: In repeating mode, `irq_pull` rises with the event and falls on the 16th `tick_4k` after it, while `flag` stays 1.
- R8: With `irq_en` at 0, `irq_pull` is 0 but `flag` still records the event. In one-shot mode, raising `irq_en` with the flag set asserts `irq_pull` at once.
- R9: A preset of 0 never sets `flag` or asserts `irq_pull`.
- R10: `flag` is set only by a counter event. `flag_clr` only clears it, and an event in the same cycle as `flag_clr` leaves `flag` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Timer enable; 0 loads and holds the preset |
| repeat_mode | input | 1 | 1 = repeating pulsed mode, 0 = one-shot latched mode |
| irq_en | input | 1 | Interrupt enable |
| src_sel | input | 2 | Tick source select |
| preset | input | CNT_W | Reload value |
| flag_clr | input | 1 | Single-cycle clear strobe for the flag |
| tick_4k | input | 1 | 4096 Hz tick enable |
| tick_64 | input | 1 | 64 Hz tick enable |
| tick_sec | input | 1 | Seconds tick enable |
| tick_min | input | 1 | Minutes tick enable |
| count | output | CNT_W | Current counter value |
| flag | output | 1 | Sticky event flag |
| irq_pull | output | 1 | Pull-down enable for the open-drain interrupt pin |

## Verification
`count` and `flag` are registered, so each is due one cycle after the tick, enable change or clear strobe that moves it. `irq_pull` is a combinational function of registered state plus `irq_en` and the mode bit. It therefore follows a change of `irq_en` in the same cycle, and follows an event one cycle after the event. The bench drives every stimulus for one cycle starting at a falling edge and reads the outputs at the next falling edge, one clock edge later. The sweep covers every source select and several presets, counting the ticks to each event.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W       = 8,
  parameter int PULSE_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             repeat_mode,
  input  logic             irq_en,
  input  logic [1:0]       src_sel,
  input  logic [CNT_W-1:0] preset,
  input  logic             flag_clr,
  input  logic             tick_4k,
  input  logic             tick_64,
  input  logic             tick_sec,
  input  logic             tick_min,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             irq_pull
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic          sel_tick;
  logic          evt;
  logic [PW-1:0] pulse_cnt;

  always_comb begin
    case (src_sel)
      2'd0:    sel_tick = tick_4k;
      2'd1:    sel_tick = tick_64;
      2'd2:    sel_tick = tick_sec;
      default: sel_tick = tick_min;
    endcase
  end

  assign evt = run_en & sel_tick & (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (!run_en)
      count <= preset;
    else if (sel_tick && count != '0)
      count <= (count == CNT_W'(1) && repeat_mode) ? preset : count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (evt)
      flag <= 1'b1;
    else if (flag_clr)
      flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_cnt <= '0;
    else if (evt && repeat_mode)
      pulse_cnt <= PW'(PULSE_TICKS);
    else if (tick_4k && pulse_cnt != '0)
      pulse_cnt <= pulse_cnt - PW'(1);
  end

  assign irq_pull = irq_en & (repeat_mode ? (pulse_cnt != '0) : flag);

  a_r2_hold_preset: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> count == $past(preset));

  a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sel_tick && count == CNT_W'(1)) |=> flag);

  a_r4_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sel_tick && count == CNT_W'(1) && repeat_mode) |=> count == $past(preset));

  a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && count == '0) |=> count == '0);

  a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(run_en && sel_tick && count == CNT_W'(1))) |=> !flag);
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       run_en = 0, repeat_mode = 0, irq_en = 0, flag_clr = 0;
  logic [1:0] src_sel = 0;
  logic [7:0] preset = 0;
  logic [3:0] ticks = 0;
  logic [7:0] count;
  logic       flag, irq_pull;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  interval_timer #(.CNT_W(8), .PULSE_TICKS(16)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .repeat_mode(repeat_mode),
    .irq_en(irq_en), .src_sel(src_sel), .preset(preset), .flag_clr(flag_clr),
    .tick_4k(ticks[0]), .tick_64(ticks[1]), .tick_sec(ticks[2]), .tick_min(ticks[3]),
    .count(count), .flag(flag), .irq_pull(irq_pull));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] t, input logic clr);
    @(negedge clk);
    ticks = t; flag_clr = clr;
    @(negedge clk);
    ticks = 0; flag_clr = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic drain();
    run_en = 0;
    for (int k = 0; k < 16; k++) step(4'b0001, 0);
    step(4'b0000, 1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset flag", flag, 0);
    chk("R6 reset irq", irq_pull, 0);
    rst_n = 1;

    // R2: disabled counter holds preset
    preset = 37; idle(); idle();
    chk("R2 load", count, 37);
    step(4'b1111, 0);
    chk("R2 hold under ticks", count, 37);

    // R1 R3 R4 sweep
    irq_en = 1; repeat_mode = 1;
    for (int s = 0; s < 4; s++) begin
      for (int p = 1; p <= 4; p++) begin
        src_sel = 2'(s); preset = 8'(p); run_en = 0; idle(); idle();
        run_en = 1;
        step(~(4'b0001 << s), 0);
        chk("R1 unselected ticks", count, p);
        for (int i = 1; i <= 2 * p; i++) begin
          step(4'b0001 << s, 0);
          if (i % p != 0) begin
            chk("R4 count", count, p - (i % p));
            if (i < p) chk("R3 no early flag", flag, 0);
          end else begin
            chk("R4 reload", count, p);
            chk("R3 flag", flag, 1);
          end
        end
        drain();
        chk("R10 clear", flag, 0);
      end
    end

    // R7 pulse length
    src_sel = 2; preset = 1; run_en = 0; idle(); run_en = 1;
    step(4'b0100, 0);
    chk("R7 pulse start", irq_pull, 1);
    for (int k = 1; k <= 16; k++) begin
      step(4'b0001, 0);
      chk("R7 pulse window", irq_pull, (k < 16) ? 1 : 0);
    end
    chk("R7 flag stays", flag, 1);
    step(4'b0000, 1);

    // R5 R6 one-shot latched
    repeat_mode = 0; src_sel = 1; preset = 3; run_en = 0; idle(); run_en = 1;
    for (int k = 0; k < 3; k++) step(4'b0010, 0);
    chk("R5 stops at zero", count, 0);
    chk("R6 irq latched", irq_pull, 1);
    for (int k = 0; k < 5; k++) step(4'b0010, 0);
    chk("R5 stays zero", count, 0);
    chk("R6 irq held", irq_pull, 1);
    step(4'b0000, 1);
    chk("R6 clear flag", flag, 0);
    chk("R6 clear irq", irq_pull, 0);
    for (int k = 0; k < 5; k++) step(4'b0010, 0);
    chk("R5 no new event", flag, 0);

    // R8 interrupt enable gating
    irq_en = 0; preset = 2; run_en = 0; idle(); run_en = 1;
    step(4'b0010, 0); step(4'b0010, 0);
    chk("R8 flag records", flag, 1);
    chk("R8 irq masked", irq_pull, 0);
    irq_en = 1; idle();
    chk("R8 unmask", irq_pull, 1);
    step(4'b0000, 1);

    // R10 set wins over clear
    preset = 1; run_en = 0; idle(); run_en = 1;
    step(4'b0010, 1);
    chk("R10 set beats clear", flag, 1);
    step(4'b0000, 1);

    // R9 zero preset
    preset = 0; run_en = 0; idle(); run_en = 1;
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      for (int k = 0; k < 20; k++) step(4'b1111, 0);
    end
    chk("R9 no flag", flag, 0);
    chk("R9 no irq", irq_pull, 0);
    chk("R9 count zero", count, 0);

    // R2 restart from preset
    src_sel = 0; preset = 5; run_en = 0; idle(); run_en = 1;
    step(4'b0001, 0); step(4'b0001, 0);
    chk("R2 counting", count, 3);
    run_en = 0; idle();
    chk("R2 reload on disable", count, 5);
    run_en = 1; step(4'b0001, 0);
    chk("R2 restart", count, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule